// File: doc/BRIEF.md
# Source-Routed Wormhole Crossbar Switch

This block is a switching element for a packet network that moves event fragments from many senders to many receivers. It has eight byte-wide inputs and eight byte-wide outputs, and any input can reach any output. Each packet arrives as a run of bytes. The first byte carries the route. The switch reads the route, removes that byte and ties the input to the chosen output. The tie lasts until the packet's end byte has passed through.

The switch stores no packets. Each input has one landing register and one spare slot that absorbs the single byte a sender may still launch after being told to stop. Congestion travels back toward the sender as a per-link stop/go level:

- An input raises its stop signal when its held byte cannot move.
- A downstream stop on an output halts that output at once.
- The same downstream stop is passed back to whichever input currently holds that output.

When several headers claim the same free output in the same cycle, a rotating-priority arbiter chooses the winner.

Top module: `xbar_switch`

## Requirements
- R1: The low 3 bits of a packet's first byte give the output index (0 to 7), and the upper 5 bits are ignored. The first byte is never forwarded. The remaining bytes leave on that output in order, and only the last of them carries the end flag.
- R2: Packets from different inputs to different outputs move at the same time. Each one streams at one byte per cycle with no gaps. An input holds at most one output at a time.
- R3: Take a data byte accepted at clock edge E. It is on the output after edge E+1. When a header is presented in cycle c to a free output, and its first data byte follows in cycle c+1, that data byte is on the output in cycle c+3.
- R4: Once an input has won an output, no other input's bytes reach that output until the winner's end byte has been forwarded. The output is then free again.
- R5: Several headers may claim one free output in the same cycle. The winner is the first requesting input at or after the output's priority pointer, counting upward with wrap-around. After each grant, the pointer moves to the input just past the winner.
- R6: An input raises `in_xoff_o` in the same cycle that its held byte cannot advance, either because it lost arbitration or because its output is stopped. The input also keeps `in_xoff_o` high while its spare slot is occupied.
- R7: A packet whose first byte also carries the end flag is consumed without forwarding anything. It leaves neither the output nor the input tied. The next packet to that output, from any input, sees the normal latency of R3.
- R8: No byte is forwarded on an output in a cycle where its `out_xoff_i` is high. In that cycle, the input holding that output shows `in_xoff_o` high. Forwarding resumes in the first cycle after `out_xoff_i` falls, so the next byte is on the output one cycle later.
- R9: While `rst_ni` is low, all of the following hold, and they hold in the first cycle after release:
  - every output is idle and every path is released;
  - every priority pointer is 0;
  - every input shows `in_xoff_o` low.
- R10: A sender may present a byte in a cycle only if `in_xoff_o` was low in the previous cycle. Under that rule no byte is lost or duplicated, however long an input is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 8 | Per-input byte strobe |
| in_data_i | input | 64 | Per-input byte, input k on bits 8k+7:8k |
| in_last_i | input | 8 | Per-input end-of-packet flag |
| in_xoff_o | output | 8 | Per-input stop request toward the sender |
| out_valid_o | output | 8 | Per-output byte strobe |
| out_data_o | output | 64 | Per-output byte, output k on bits 8k+7:8k |
| out_last_o | output | 8 | Per-output end-of-packet flag |
| out_xoff_i | input | 8 | Per-output stop request from downstream |

## Verification
Each result has a fixed timing:
- A header presented in cycle c to an idle output is granted in cycle c+1, and its first data byte is on the output in cycle c+3.
- A stalled input's `in_xoff_o` rises in the same cycle that its held byte is refused.
- A downstream stop blanks the output from the following cycle until one cycle after the stop falls.

The bench drives inputs just after each rising edge and samples all outputs and `in_xoff_o` at the falling edge of the same cycle. It logs every output byte with its cycle number. Each latency, gap and stall check therefore compares against a cycle index worked out from the rules above, and never against a wait for an event.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned XB_DATA_W = 8;

  typedef struct packed {
    logic                 last;
    logic [XB_DATA_W-1:0] data;
  } xb_flit_t;
endpackage

// File: rtl/xbar_ingress.sv
module xbar_ingress
  import xbar_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  xb_flit_t           in_flit_i,
  input  logic [N_PORTS-1:0] out_xoff_i,
  input  logic               grant_i,
  output logic               req_o,
  output logic [SEL_W-1:0]   req_port_o,
  output xb_flit_t           head_o,
  output logic               fwd_o,
  output logic               path_active_o,
  output logic [SEL_W-1:0]   path_port_o,
  output logic               xoff_o
);
  logic             head_v_q, skid_v_q, path_q;
  xb_flit_t         head_q, skid_q;
  logic [SEL_W-1:0] port_q;
  logic             hdr_stage, pop, out_stop;

  assign out_stop      = path_q && out_xoff_i[port_q];
  assign hdr_stage     = head_v_q && !path_q;
  assign req_o         = hdr_stage;
  assign req_port_o    = head_q.data[SEL_W-1:0];
  assign head_o        = head_q;
  assign fwd_o         = head_v_q && path_q && !out_xoff_i[port_q];
  assign pop           = (hdr_stage && grant_i) || fwd_o;
  assign path_active_o = path_q;
  assign path_port_o   = port_q;
  // stop the sender whenever the spare slot is in use or the head is refused
  assign xoff_o        = skid_v_q || (head_v_q && !pop) || out_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_v_q <= 1'b0;
      skid_v_q <= 1'b0;
      head_q   <= '0;
      skid_q   <= '0;
    end else if (pop) begin
      if (skid_v_q) begin
        head_q   <= skid_q;
        head_v_q <= 1'b1;
        skid_v_q <= in_valid_i;
        if (in_valid_i) skid_q <= in_flit_i;
      end else begin
        head_v_q <= in_valid_i;
        if (in_valid_i) head_q <= in_flit_i;
      end
    end else if (in_valid_i) begin
      if (!head_v_q) begin
        head_v_q <= 1'b1;
        head_q   <= in_flit_i;
      end else begin
        skid_v_q <= 1'b1;
        skid_q   <= in_flit_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      path_q <= 1'b0;
      port_q <= '0;
    end else if (hdr_stage && grant_i && !head_q.last) begin
      path_q <= 1'b1;
      port_q <= req_port_o;
    end else if (fwd_o && head_q.last) begin
      path_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [N_PORTS-1:0] req_i,
  output logic [N_PORTS-1:0] gnt_o,
  output logic               gnt_v_o,
  output logic [SEL_W-1:0]   gnt_idx_o
);
  logic [SEL_W-1:0] ptr_q;

  function automatic logic [SEL_W-1:0] wrap_idx(input int unsigned a);
    return SEL_W'(a % N_PORTS);
  endfunction

  always_comb begin
    gnt_v_o   = 1'b0;
    gnt_idx_o = '0;
    for (int unsigned off = 0; off < N_PORTS; off++) begin
      if (en_i && !gnt_v_o && req_i[wrap_idx(int'(ptr_q) + off)]) begin
        gnt_v_o   = 1'b1;
        gnt_idx_o = wrap_idx(int'(ptr_q) + off);
      end
    end
    gnt_o = '0;
    if (gnt_v_o) gnt_o[gnt_idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (gnt_v_o) ptr_q <= wrap_idx(int'(gnt_idx_o) + 1);
  end
endmodule

// File: rtl/xbar_egress.sv
module xbar_egress
  import xbar_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  xb_flit_t           heads_i [N_PORTS],
  input  logic [N_PORTS-1:0] fwd_i,
  input  logic               gnt_v_i,
  input  logic [SEL_W-1:0]   gnt_idx_i,
  output logic               busy_o,
  output logic [SEL_W-1:0]   owner_o,
  output logic               out_valid_o,
  output xb_flit_t           out_flit_o
);
  logic             busy_q, take, valid_q;
  logic [SEL_W-1:0] owner_q;
  xb_flit_t         cur, flit_q;

  assign cur         = heads_i[owner_q];
  assign take        = busy_q && fwd_i[owner_q];
  assign busy_o      = busy_q;
  assign owner_o     = owner_q;
  assign out_valid_o = valid_q;
  assign out_flit_o  = flit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      flit_q  <= '0;
    end else begin
      valid_q <= take;
      if (take) flit_q <= cur;
    end
  end

  // a header-only packet wins the grant but never locks the output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (take && cur.last) begin
      busy_q <= 1'b0;
    end else if (gnt_v_i && !heads_i[gnt_idx_i].last) begin
      busy_q  <= 1'b1;
      owner_q <= gnt_idx_i;
    end
  end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int unsigned N_PORTS = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             in_valid_i,
  input  logic [N_PORTS*XB_DATA_W-1:0]   in_data_i,
  input  logic [N_PORTS-1:0]             in_last_i,
  output logic [N_PORTS-1:0]             in_xoff_o,
  output logic [N_PORTS-1:0]             out_valid_o,
  output logic [N_PORTS*XB_DATA_W-1:0]   out_data_o,
  output logic [N_PORTS-1:0]             out_last_o,
  input  logic [N_PORTS-1:0]             out_xoff_i
);
  localparam int unsigned SEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  xb_flit_t             head     [N_PORTS];
  logic [N_PORTS-1:0]   req, fwd, gnt_in, path_active;
  logic [SEL_W-1:0]     req_port [N_PORTS];
  logic [SEL_W-1:0]     path_port[N_PORTS];
  logic [N_PORTS-1:0]   gnt_mat  [N_PORTS];
  logic [N_PORTS-1:0]   out_busy;
  logic [SEL_W-1:0]     out_owner[N_PORTS];
  logic [N_PORTS*SEL_W-1:0] out_owner_flat, path_port_flat;

  always_comb begin
    gnt_in = '0;
    for (int unsigned o = 0; o < N_PORTS; o++) gnt_in |= gnt_mat[o];
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    xb_flit_t flit_in;
    assign flit_in = '{last: in_last_i[i], data: in_data_i[i*XB_DATA_W +: XB_DATA_W]};
    assign path_port_flat[i*SEL_W +: SEL_W] = path_port[i];

    xbar_ingress #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_ingress (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .in_valid_i   (in_valid_i[i]),
      .in_flit_i    (flit_in),
      .out_xoff_i   (out_xoff_i),
      .grant_i      (gnt_in[i]),
      .req_o        (req[i]),
      .req_port_o   (req_port[i]),
      .head_o       (head[i]),
      .fwd_o        (fwd[i]),
      .path_active_o(path_active[i]),
      .path_port_o  (path_port[i]),
      .xoff_o       (in_xoff_o[i])
    );
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    logic [N_PORTS-1:0] req_col;
    logic               gnt_v;
    logic [SEL_W-1:0]   gnt_idx;
    xb_flit_t           flit_out;

    always_comb begin
      for (int unsigned i = 0; i < N_PORTS; i++)
        req_col[i] = req[i] && (req_port[i] == SEL_W'(o));
    end

    xbar_rr_arb #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_arb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (!out_busy[o]),
      .req_i    (req_col),
      .gnt_o    (gnt_mat[o]),
      .gnt_v_o  (gnt_v),
      .gnt_idx_o(gnt_idx)
    );

    xbar_egress #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_egress (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .heads_i    (head),
      .fwd_i      (fwd),
      .gnt_v_i    (gnt_v),
      .gnt_idx_i  (gnt_idx),
      .busy_o     (out_busy[o]),
      .owner_o    (out_owner[o]),
      .out_valid_o(out_valid_o[o]),
      .out_flit_o (flit_out)
    );

    assign out_data_o[o*XB_DATA_W +: XB_DATA_W] = flit_out.data;
    assign out_last_o[o]                        = flit_out.last;
    assign out_owner_flat[o*SEL_W +: SEL_W]     = out_owner[o];
  end
endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned SEL_W   = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_PORTS-1:0]       in_xoff_o,
  input logic [N_PORTS-1:0]       out_valid_o,
  input logic [N_PORTS-1:0]       out_last_o,
  input logic [N_PORTS-1:0]       out_xoff_i,
  input logic [N_PORTS-1:0]       busy_i,
  input logic [N_PORTS*SEL_W-1:0] owner_i,
  input logic [N_PORTS-1:0]       path_active_i,
  input logic [N_PORTS*SEL_W-1:0] path_port_i
);
  logic [N_PORTS-1:0] owns [N_PORTS];

  always_comb begin
    for (int unsigned i = 0; i < N_PORTS; i++)
      for (int unsigned o = 0; o < N_PORTS; o++)
        owns[i][o] = busy_i[o] && (owner_i[o*SEL_W +: SEL_W] == SEL_W'(i));
  end

  assert_reset_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (out_valid_o == '0 && in_xoff_o == '0));

  for (genvar o = 0; o < N_PORTS; o++) begin : g_o
    assert_stop_fwd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_xoff_i[o] |=> !out_valid_o[o]);

    assert_owner_path_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i[o] |-> (path_active_i[owner_i[o*SEL_W +: SEL_W]] &&
                     path_port_i[owner_i[o*SEL_W +: SEL_W]*SEL_W +: SEL_W] == SEL_W'(o)));

    assert_owner_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i[o] |=> (!busy_i[o] || $stable(owner_i[o*SEL_W +: SEL_W])));

    assert_end_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && out_last_o[o]) |-> !busy_i[o]);
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_i
    assert_single_path_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owns[i]));
  end
endmodule

bind xbar_switch xbar_switch_chk #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_xbar_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_xoff_o    (in_xoff_o),
  .out_valid_o  (out_valid_o),
  .out_last_o   (out_last_o),
  .out_xoff_i   (out_xoff_i),
  .busy_i       (out_busy),
  .owner_i      (out_owner_flat),
  .path_active_i(path_active),
  .path_port_i  (path_port_flat)
);

// File: tb/xbar_switch_test.sv
`timescale 1ns/1ps
module xbar_switch_test;
  localparam int NP = 8;
  // src_a, dst_a, src_b, dst_b, data length
  localparam int VEC [6][5] = '{
    '{0, 3, 5, 1, 4},
    '{1, 0, 2, 7, 2},
    '{3, 5, 4, 6, 6},
    '{6, 2, 7, 4, 1},
    '{2, 1, 0, 0, 3},
    '{7, 7, 3, 2, 5}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   in_valid_i = '0, in_last_i = '0, out_xoff_i = '0;
  logic [NP*8-1:0] in_data_i = '0;
  logic [NP-1:0]   in_xoff_o, out_valid_o, out_last_o;
  logic [NP*8-1:0] out_data_o;

  logic [8:0] tx_q   [NP][$];
  logic [8:0] rx_q   [NP][$];
  int         rx_cyc [NP][$];
  logic [NP-1:0] prev_xoff = '0, ds_xoff = '0;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xbar_switch #(.N_PORTS(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_xoff_o(in_xoff_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_last_o(out_last_o),
    .out_xoff_i(out_xoff_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int base_of(input int v, input int src);
    return (v * 40 + src * 5 + 16) % 256;
  endfunction

  task automatic queue_pkt(input int src, input int dst, input int len, input int base);
    tx_q[src].push_back({(len == 0), 5'(src + 1), 3'(dst)});
    for (int k = 0; k < len; k++)
      tx_q[src].push_back({(k == len - 1), 8'(base + k)});
  endtask

  task automatic step();
    @(posedge clk); #1;
    cyc++;
    out_xoff_i = ds_xoff;
    for (int i = 0; i < NP; i++) begin
      if (tx_q[i].size() > 0 && !prev_xoff[i]) begin
        in_valid_i[i]       = 1'b1;
        in_last_i[i]        = tx_q[i][0][8];
        in_data_i[i*8 +: 8] = tx_q[i][0][7:0];
        void'(tx_q[i].pop_front());
      end else begin
        in_valid_i[i]       = 1'b0;
        in_last_i[i]        = 1'b0;
        in_data_i[i*8 +: 8] = '0;
      end
    end
    @(negedge clk);
    for (int o = 0; o < NP; o++) begin
      if (out_valid_o[o]) begin
        rx_q[o].push_back({out_last_o[o], out_data_o[o*8 +: 8]});
        rx_cyc[o].push_back(cyc);
      end
    end
    prev_xoff = in_xoff_o;
  endtask

  task automatic run_idle();
    int guard;
    guard = 0;
    while (guard < 500) begin
      bit busy;
      busy = 0;
      for (int i = 0; i < NP; i++) if (tx_q[i].size() > 0) busy = 1;
      if (!busy) break;
      step();
      guard++;
    end
    repeat (6) step();
  endtask

  task automatic clear_rx();
    for (int o = 0; o < NP; o++) begin
      rx_q[o].delete();
      rx_cyc[o].delete();
    end
  endtask

  task automatic check_pkt(input int o, input int off, input int len, input int base, input string req);
    int bad;
    int act;
    int exp;
    bad = 0; act = 0; exp = 0;
    if (rx_q[o].size() < off + len) begin
      bad = 1; act = rx_q[o].size(); exp = off + len;
    end else begin
      for (int k = 0; k < len; k++) begin
        if (!bad && rx_q[o][off+k] != {(k == len - 1), 8'(base + k)}) begin
          bad = 1; act = int'(rx_q[o][off+k]); exp = int'({(k == len - 1), 8'(base + k)});
        end
      end
    end
    chk(!bad, req, act, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ds_xoff = '0; out_xoff_i = '0; in_valid_i = '0; in_last_i = '0; in_data_i = '0;
    prev_xoff = '0;
    for (int i = 0; i < NP; i++) tx_q[i].delete();
    clear_rx();
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(out_valid_o == '0, "R9 outputs idle", int'(out_valid_o), 0);
    chk(in_xoff_o == '0, "R9 inputs xon", int'(in_xoff_o), 0);

    // table of concurrent packet pairs on distinct outputs
    for (int v = 0; v < 6; v++) begin
      int sa, da, sb, db, len, start, stray;
      sa = VEC[v][0]; da = VEC[v][1]; sb = VEC[v][2]; db = VEC[v][3]; len = VEC[v][4];
      clear_rx();
      queue_pkt(sa, da, len, base_of(v, sa));
      queue_pkt(sb, db, len, base_of(v, sb));
      start = cyc + 1;
      run_idle();
      check_pkt(da, 0, len, base_of(v, sa), "R1 route a");
      check_pkt(db, 0, len, base_of(v, sb), "R1 route b");
      stray = 0;
      for (int o = 0; o < NP; o++) if (o != da && o != db) stray += rx_q[o].size();
      chk(stray == 0, "R1 no stray bytes", stray, 0);
      chk(rx_cyc[da].size() > 0 && rx_cyc[da][0] == start + 3, "R3 first byte latency",
          rx_cyc[da].size() > 0 ? rx_cyc[da][0] : -1, start + 3);
      chk(rx_cyc[da].size() == len && rx_cyc[da][len-1] - rx_cyc[da][0] == len - 1, "R2 full rate a",
          rx_cyc[da].size(), len);
      chk(rx_cyc[db].size() == len && rx_cyc[db][len-1] - rx_cyc[db][0] == len - 1, "R2 full rate b",
          rx_cyc[db].size(), len);
    end

    // R5 / R6 / R4: contention on output 4 from fresh pointer
    do_reset();
    queue_pkt(2, 4, 3, 8'h40);
    queue_pkt(5, 4, 3, 8'h50);
    step();
    step();
    chk(in_xoff_o[5] == 1'b1, "R6 loser xoff", int'(in_xoff_o[5]), 1);
    chk(in_xoff_o[2] == 1'b0, "R6 winner xon", int'(in_xoff_o[2]), 0);
    run_idle();
    check_pkt(4, 0, 3, 8'h40, "R5 pointer 0 picks input 2");
    check_pkt(4, 3, 3, 8'h50, "R4 input 5 follows whole packet R10");
    chk(rx_q[4].size() == 6, "R10 no loss or duplicate", rx_q[4].size(), 6);
    clear_rx();
    queue_pkt(1, 4, 2, 8'h60);
    queue_pkt(7, 4, 2, 8'h70);
    run_idle();
    check_pkt(4, 0, 2, 8'h70, "R5 pointer 6 picks input 7");
    check_pkt(4, 2, 2, 8'h60, "R5 input 1 second");

    // R8: downstream stop on output 6 mid-packet
    clear_rx();
    queue_pkt(3, 6, 10, 8'h80);
    begin
      int guard;
      guard = 0;
      while (rx_q[6].size() < 2 && guard < 50) begin step(); guard++; end
    end
    ds_xoff[6] = 1'b1;
    step();
    chk(in_xoff_o[3] == 1'b1, "R8 owner sees xoff", int'(in_xoff_o[3]), 1);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(out_valid_o[6] == 1'b0, "R8 output halted", int'(out_valid_o[6]), 0);
    end
    ds_xoff[6] = 1'b0;
    step();
    chk(out_valid_o[6] == 1'b0, "R8 last halted cycle", int'(out_valid_o[6]), 0);
    step();
    chk(out_valid_o[6] == 1'b1, "R8 resume after xon", int'(out_valid_o[6]), 1);
    run_idle();
    check_pkt(6, 0, 10, 8'h80, "R10 stalled packet intact");

    // R7: header-only packet leaves nothing tied
    clear_rx();
    queue_pkt(0, 2, 0, 0);
    step();
    queue_pkt(1, 2, 3, 8'hA0);
    begin
      int start;
      start = cyc + 1;
      run_idle();
      check_pkt(2, 0, 3, 8'hA0, "R7 nothing forwarded for header-only");
      chk(rx_q[2].size() == 3, "R7 byte count", rx_q[2].size(), 3);
      chk(rx_cyc[2].size() > 0 && rx_cyc[2][0] == start + 3, "R7 output free, R3 latency",
          rx_cyc[2].size() > 0 ? rx_cyc[2][0] : -1, start + 3);
    end
    clear_rx();
    queue_pkt(0, 5, 2, 8'hB0);
    run_idle();
    check_pkt(5, 0, 2, 8'hB0, "R7 input path released");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule